// File: doc/BRIEF.md
# Keyboard Dual-Priority Reply Queue

This block is the output byte buffer of a keyboard device model that talks to a host over a two-wire serial keyboard link. Two kinds of bytes leave the keyboard: scancodes produced by key activity, and reply bytes answering host commands. Both kinds live in one shared 256-byte circular store. Scancodes are appended at a write pointer. Reply bytes are placed in front of the read pointer by stepping it backward, so replies always leave before any scancode that is already waiting. A separate reply-end marker records where the reply region stops. It holds an all-ones value when no replies are pending.

When the host sends a new command, the command decoder pulses a command-start strobe. That strobe discards every reply byte still waiting by jumping the read pointer to the reply-end marker. Queued scancodes are left in place. The serializer takes bytes from a valid/ready pop port, and a total-count output reports the combined depth of both regions.

Top module: `kbd_reply_queue`

## Requirements
- R1: A synchronous active-high reset empties the queue: on the cycle after reset, `total_cnt` is 0 and `pop_valid` is low.
- R2: Scancodes pushed with `scan_push` are popped in the order they were pushed. Each accepted push adds one to `total_cnt`.
- R3: At most 16 scancode bytes are held. A push made while 16 scancode bytes are pending is dropped. This holds even if a pop happens in the same cycle, because fullness is judged on the state before that edge.
- R4: A reply write (`rep_wr` with `rep_len` of 1 to 3) queues `rep_len` bytes. Lane 0 (`rep_data[7:0]`) leaves first, then lane 1 (`rep_data[15:8]`), then lane 2 (`rep_data[23:16]`). All reply bytes are popped before any scancode that is pending. A `rep_len` of 0 queues nothing.
- R5: A reply write made while earlier reply bytes are still pending, with no command start in between, places the new bytes ahead of the older reply bytes.
- R6: A `cmd_start` pulse discards all pending reply bytes and leaves pending scancodes and their order unchanged.
- R7: When `cmd_start` and `rep_wr` occur in the same cycle, the old replies are discarded first and the new reply bytes are then queued.
- R8: `total_cnt` always equals the number of pending reply bytes plus the number of pending scancode bytes.
- R9: `pop_valid` is high exactly when `total_cnt` is non-zero. A `pop_ready` while the queue is empty changes nothing.
- R10: Once the last reply byte has been popped, the reply region is empty. A later `cmd_start` then removes no scancode.
- R11: Pointers wrap modulo 256. A reply written when the read pointer is 0 lands at the top of the store. Streams longer than 256 bytes keep their order.
- R12: While `pop_valid` is high and `pop_ready` is low, and no reply write or command start occurs, `pop_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_push | input | 1 | Append one scancode byte |
| scan_data | input | 8 | Scancode byte to append |
| rep_wr | input | 1 | Queue a group of reply bytes |
| rep_len | input | 2 | Number of reply bytes, 0 to 3 |
| rep_data | input | 24 | Reply bytes; lane 0 in bits 7:0 leaves first |
| cmd_start | input | 1 | New host command accepted; flush pending replies |
| pop_ready | input | 1 | Consumer takes the presented byte |
| pop_valid | output | 1 | A byte is presented |
| pop_data | output | 8 | Next byte to send |
| total_cnt | output | 9 | Bytes pending in both regions |

## Verification
The hardest case to reach from the ports is an update where several pointer moves land on the same edge. Examples are a pop of the final reply byte together with a command start, a flush together with a new reply write, and a push into a full scancode region while a pop frees a slot. The stimulus builds these states on purpose: it stacks reply groups over queued scancodes, then fires the strobes in the same cycle. A long simultaneous push-and-pop stream carries both pointers past the 255-to-0 boundary. A reference model of two ordered byte lists predicts every presented byte and count.

// File: rtl/kq_pkg.sv
package kq_pkg;

    localparam int KQ_AW       = 8;
    localparam int KQ_DW       = 8;
    localparam int KQ_DEPTH    = 1 << KQ_AW;
    localparam int KQ_SCAN_MAX = 16;
    localparam int KQ_REP_MAX  = 3;

    typedef logic [KQ_AW-1:0] kq_ptr_t;
    typedef logic [KQ_AW:0]   kq_mark_t;
    typedef logic [KQ_DW-1:0] kq_byte_t;

    localparam kq_mark_t KQ_MARK_NONE = '1;

    typedef struct packed {
        kq_ptr_t  rd;
        kq_ptr_t  wr;
        kq_mark_t rend;
    } kq_ptrs_t;

    function automatic logic mark_live(input kq_mark_t m);
        return ~m[KQ_AW];
    endfunction

    function automatic kq_ptr_t ring_dist(input kq_ptr_t hi, input kq_ptr_t lo);
        return hi - lo;
    endfunction

endpackage

// File: rtl/kq_ptr_ctrl.sv
module kq_ptr_ctrl
    import kq_pkg::*;
#(
    parameter int SCAN_MAX = KQ_SCAN_MAX,
    parameter int REP_MAX  = KQ_REP_MAX,
    localparam int LEN_W   = $clog2(REP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_push,
    input  logic             rep_wr,
    input  logic [LEN_W-1:0] rep_len,
    input  logic             cmd_start,
    input  logic             pop_ready,
    output kq_ptr_t          rd_ptr,
    output kq_ptr_t          wr_ptr,
    output logic             scan_we,
    output logic             rep_do,
    output kq_ptr_t          rep_base,
    output logic [KQ_AW:0]   total_cnt,
    output kq_ptr_t          rep_cnt,
    output kq_ptr_t          scan_cnt,
    output logic             rend_vld
);

    kq_ptrs_t cur, nxt;

    kq_ptr_t  scan_start, total8;
    logic     do_pop;
    kq_ptr_t  rd_a, rd_b, rd_c;
    kq_mark_t rend_a, rend_b, rend_c;

    always_comb begin
        rend_vld   = mark_live(cur.rend);
        scan_start = rend_vld ? cur.rend[KQ_AW-1:0] : cur.rd;
        rep_cnt    = rend_vld ? ring_dist(cur.rend[KQ_AW-1:0], cur.rd) : '0;
        scan_cnt   = ring_dist(cur.wr, scan_start);
        total8     = ring_dist(cur.wr, cur.rd);
        total_cnt  = {1'b0, total8};
    end

    // Stage A: pop of the head byte; marker retires when reached.
    always_comb begin
        do_pop = pop_ready && (total8 != '0);
        rd_a   = cur.rd + KQ_AW'(do_pop);
        rend_a = cur.rend;
        if (rend_vld && (rd_a == cur.rend[KQ_AW-1:0]))
            rend_a = KQ_MARK_NONE;
    end

    // Stage B: command start flushes whatever replies remain.
    always_comb begin
        rd_b   = rd_a;
        rend_b = rend_a;
        if (cmd_start) begin
            if (mark_live(rend_a))
                rd_b = rend_a[KQ_AW-1:0];
            rend_b = KQ_MARK_NONE;
        end
    end

    // Stage C: reply bytes go in front of the read pointer.
    always_comb begin
        rep_do = rep_wr && (rep_len != '0);
        rd_c   = rd_b;
        rend_c = rend_b;
        if (rep_do) begin
            rd_c = rd_b - KQ_AW'(rep_len);
            if (!mark_live(rend_b))
                rend_c = {1'b0, rd_b};
        end
        rep_base = rd_c;
    end

    always_comb begin
        scan_we  = scan_push && (scan_cnt < KQ_AW'(SCAN_MAX));
        nxt.rd   = rd_c;
        nxt.rend = rend_c;
        nxt.wr   = cur.wr + KQ_AW'(scan_we);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.rd   <= '0;
            cur.wr   <= '0;
            cur.rend <= KQ_MARK_NONE;
        end else begin
            cur <= nxt;
        end
    end

    assign rd_ptr = cur.rd;
    assign wr_ptr = cur.wr;

endmodule

// File: rtl/kq_store.sv
module kq_store
    import kq_pkg::*;
#(
    parameter int REP_MAX = KQ_REP_MAX,
    localparam int LEN_W  = $clog2(REP_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   scan_we,
    input  kq_ptr_t                scan_addr,
    input  kq_byte_t               scan_data,
    input  logic                   rep_do,
    input  logic [LEN_W-1:0]       rep_len,
    input  kq_ptr_t                rep_base,
    input  logic [REP_MAX*KQ_DW-1:0] rep_data,
    input  kq_ptr_t                rd_addr,
    output kq_byte_t               rd_data
);

    kq_byte_t mem [KQ_DEPTH];

    logic     lane_we   [REP_MAX];
    kq_ptr_t  lane_addr [REP_MAX];
    kq_byte_t lane_data [REP_MAX];

    for (genvar g = 0; g < REP_MAX; g++) begin : g_lane
        assign lane_we[g]   = rep_do && ({1'b0, rep_len} > (LEN_W+1)'(g));
        assign lane_addr[g] = rep_base + KQ_AW'(g);
        assign lane_data[g] = rep_data[g*KQ_DW +: KQ_DW];
    end

    always_ff @(posedge clk) begin
        if (scan_we)
            mem[scan_addr] <= scan_data;
        for (int i = 0; i < REP_MAX; i++) begin
            if (lane_we[i])
                mem[lane_addr[i]] <= lane_data[i];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/kbd_reply_queue.sv
module kbd_reply_queue
    import kq_pkg::*;
#(
    parameter int SCAN_MAX = KQ_SCAN_MAX,
    parameter int REP_MAX  = KQ_REP_MAX,
    localparam int LEN_W   = $clog2(REP_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scan_push,
    input  logic [KQ_DW-1:0]         scan_data,
    input  logic                     rep_wr,
    input  logic [LEN_W-1:0]         rep_len,
    input  logic [REP_MAX*KQ_DW-1:0] rep_data,
    input  logic                     cmd_start,
    input  logic                     pop_ready,
    output logic                     pop_valid,
    output logic [KQ_DW-1:0]         pop_data,
    output logic [KQ_AW:0]           total_cnt
);

    kq_ptr_t rd_ptr, wr_ptr, rep_base, rep_cnt, scan_cnt;
    logic    scan_we, rep_do, rend_vld;

    kq_ptr_ctrl #(.SCAN_MAX(SCAN_MAX), .REP_MAX(REP_MAX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .scan_push (scan_push),
        .rep_wr    (rep_wr),
        .rep_len   (rep_len),
        .cmd_start (cmd_start),
        .pop_ready (pop_ready),
        .rd_ptr    (rd_ptr),
        .wr_ptr    (wr_ptr),
        .scan_we   (scan_we),
        .rep_do    (rep_do),
        .rep_base  (rep_base),
        .total_cnt (total_cnt),
        .rep_cnt   (rep_cnt),
        .scan_cnt  (scan_cnt),
        .rend_vld  (rend_vld)
    );

    kq_store #(.REP_MAX(REP_MAX)) u_store (
        .clk       (clk),
        .scan_we   (scan_we),
        .scan_addr (wr_ptr),
        .scan_data (scan_data),
        .rep_do    (rep_do),
        .rep_len   (rep_len),
        .rep_base  (rep_base),
        .rep_data  (rep_data),
        .rd_addr   (rd_ptr),
        .rd_data   (pop_data)
    );

    assign pop_valid = (total_cnt != '0);

endmodule

// File: rtl/kq_checker.sv
module kq_checker
    import kq_pkg::*;
#(
    parameter int SCAN_MAX = KQ_SCAN_MAX,
    parameter int LEN_W    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             scan_push,
    input logic             rep_wr,
    input logic [LEN_W-1:0] rep_len,
    input logic             cmd_start,
    input logic             pop_ready,
    input logic             pop_valid,
    input logic [KQ_DW-1:0] pop_data,
    input logic [KQ_AW:0]   total_cnt,
    input kq_ptr_t          rep_cnt,
    input kq_ptr_t          scan_cnt,
    input logic             rend_vld
);

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (total_cnt == '0 && !pop_valid));

    p_scan_cap_r3: assert property (@(posedge clk) disable iff (rst)
        scan_cnt <= KQ_AW'(SCAN_MAX));

    p_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !rep_wr) |=> (rep_cnt == '0));

    p_flush_then_write_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && rep_wr) |=> (rep_cnt == KQ_AW'($past(rep_len))));

    p_count_sum_r8: assert property (@(posedge clk) disable iff (rst)
        total_cnt == ({1'b0, rep_cnt} + {1'b0, scan_cnt}));

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (total_cnt == '0 && !scan_push && !rep_wr) |=> (total_cnt == '0 && !pop_valid));

    p_marker_r10: assert property (@(posedge clk) disable iff (rst)
        rend_vld == (rep_cnt != '0));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && !pop_ready && !rep_wr && !cmd_start) |=> (pop_valid && $stable(pop_data)));

endmodule

bind kbd_reply_queue kq_checker #(.SCAN_MAX(SCAN_MAX), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_push (scan_push),
    .rep_wr    (rep_wr),
    .rep_len   (rep_len),
    .cmd_start (cmd_start),
    .pop_ready (pop_ready),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .total_cnt (total_cnt),
    .rep_cnt   (rep_cnt),
    .scan_cnt  (scan_cnt),
    .rend_vld  (rend_vld)
);

// File: tb/tb_kbd_reply_queue.sv
module tb_kbd_reply_queue;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_push = 1'b0;
    logic [7:0]  scan_data = '0;
    logic        rep_wr = 1'b0;
    logic [1:0]  rep_len = '0;
    logic [23:0] rep_data = '0;
    logic        cmd_start = 1'b0;
    logic        pop_ready = 1'b0;
    logic        pop_valid;
    logic [7:0]  pop_data;
    logic [8:0]  total_cnt;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string cur_req = "R2";

    byte unsigned exp_rep[$];
    byte unsigned exp_scan[$];

    always #5 clk = ~clk;

    kbd_reply_queue dut (
        .clk(clk), .rst(rst), .scan_push(scan_push), .scan_data(scan_data),
        .rep_wr(rep_wr), .rep_len(rep_len), .rep_data(rep_data),
        .cmd_start(cmd_start), .pop_ready(pop_ready), .pop_valid(pop_valid),
        .pop_data(pop_data), .total_cnt(total_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compares the presented outputs with the scoreboard queues.
    task automatic monitor();
        int tot;
        int head;
        tot = exp_rep.size() + exp_scan.size();
        chk(int'(total_cnt) == tot, "R8", int'(total_cnt), tot);
        chk(pop_valid == (tot != 0), "R9", int'(pop_valid), int'(tot != 0));
        if (tot != 0) begin
            head = (exp_rep.size() != 0) ? int'(exp_rep[0]) : int'(exp_scan[0]);
            chk(int'(pop_data) == head, cur_req, int'(pop_data), head);
        end
    endtask

    // Driver: applies one cycle of stimulus and updates the expected queues.
    task automatic step(input bit sp, input byte unsigned sd, input bit rw,
                        input int len, input logic [23:0] rd, input bit cmd,
                        input bit rdy);
        int pre_scan;
        @(negedge clk);
        monitor();
        scan_push = sp; scan_data = sd; rep_wr = rw; rep_len = 2'(len);
        rep_data = rd; cmd_start = cmd; pop_ready = rdy;
        pre_scan = exp_scan.size();
        if (rdy) begin
            if (exp_rep.size() != 0) void'(exp_rep.pop_front());
            else if (exp_scan.size() != 0) void'(exp_scan.pop_front());
        end
        if (cmd) exp_rep.delete();
        if (rw) begin
            for (int i = len - 1; i >= 0; i--)
                exp_rep.push_front(rd[i*8 +: 8]);
        end
        if (sp && pre_scan < 16) exp_scan.push_back(sd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        idle(2);

        cur_req = "R9";                         // pops on an empty queue
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 1);

        cur_req = "R11";                        // reply at rd=0 wraps to the top
        step(0, 0, 1, 2, 24'h00_B2B1, 0, 0);
        idle(1);
        drain();

        cur_req = "R2";
        for (int i = 0; i < 5; i++) step(1, byte'(8'h10 + i), 0, 0, 0, 0, 0);
        drain();

        cur_req = "R3";
        for (int i = 0; i < 18; i++) step(1, byte'(8'h20 + i), 0, 0, 0, 0, 0);
        step(1, 8'h3F, 0, 0, 0, 0, 1);          // full: dropped despite pop
        drain();

        cur_req = "R4";
        for (int i = 0; i < 3; i++) step(1, byte'(8'h40 + i), 0, 0, 0, 0, 0);
        step(0, 0, 1, 3, 24'hA3_A2_A1, 0, 0);
        step(0, 0, 1, 0, 24'hEE_EE_EE, 0, 0);   // zero length queues nothing
        drain();
        step(1, 8'h48, 1, 1, 24'h00_00_C1, 0, 0);
        drain();

        cur_req = "R5";
        step(1, 8'h50, 0, 0, 0, 0, 0);
        step(0, 0, 1, 2, 24'h00_D2D1, 0, 0);
        step(0, 0, 1, 2, 24'h00_E2E1, 0, 0);
        drain();

        cur_req = "R6";
        step(1, 8'h60, 0, 0, 0, 0, 0);
        step(1, 8'h61, 0, 0, 0, 0, 0);
        step(0, 0, 1, 3, 24'hF3_F2_F1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1, 0);
        idle(1);
        drain();

        cur_req = "R7";
        step(1, 8'h70, 0, 0, 0, 0, 0);
        step(0, 0, 1, 2, 24'h00_9291, 0, 0);
        step(0, 0, 1, 1, 24'h00_00_95, 1, 0);
        idle(1);
        drain();

        cur_req = "R10";
        step(1, 8'h80, 0, 0, 0, 0, 0);
        step(1, 8'h81, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 24'h00_00_85, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);              // last reply leaves
        step(0, 0, 0, 0, 0, 1, 0);              // flush must keep scancodes
        idle(1);
        step(0, 0, 1, 2, 24'h00_8887, 0, 1);    // pop scancode and stack reply
        step(0, 0, 0, 0, 0, 1, 1);              // pop last-but-one reply + flush
        idle(1);
        drain();

        cur_req = "R12";
        step(1, 8'hC0, 0, 0, 0, 0, 0);
        step(1, 8'hC1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, byte'(8'hC2 + i), 0, 0, 0, 0, 0);
        idle(3);
        drain();

        cur_req = "R11";                        // long stream wraps both pointers
        for (int i = 0; i < 300; i++) step(1, byte'(i), 0, 0, 0, 0, (i > 2));
        step(0, 0, 1, 3, 24'h33_22_11, 0, 0);
        drain();

        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule